// File: doc/BRIEF.md
# Key-Protected DRAM Configuration Register Bank

This block is the software-visible register space of a DRAM controller. It holds a word-addressed array of 32-bit registers behind a plain request bus with valid, write, byte address and write data. Read data returns in the same cycle. Register 0 is a lock. Only one 32-bit key value opens the bank. Any other value written there closes it again. While the bank is closed, writes to every other register are dropped.

A parameter selects one of two silicon variants. The configuration register at byte offset 0x04 keeps its read-only fields on every write. Its fixed bits are re-applied on every write. These fixed bits come from the variant and from a RAM-size strap input, which is sampled while reset is asserted. On variant B, two status registers have write filters. These filters make the PHY always read as idle and the ECC self-test always read as finished without failure. Out-of-range accesses and writes dropped by the lock raise a one-cycle error pulse.

Top module: `memctl_cfg_bank`

## Requirements
- R1: A write to byte offset 0x00 stores 1 when the data is exactly 32'hFC600309 and stores 0 for any other data. Bits 31:1 of that register always read 0.
- R2: While register 0 reads 0, writes to every other offset leave the registers unchanged. A write to offset 0x00 is always accepted, locked or not.
- R3: A write to offset 0x04 that the lock accepts stores the data with the variant's read-only bits cleared, ORed with the variant's fixed configuration value.
- R4: Variant A (VARIANT = VAR_A) has read-only mask 32'hFFFFF84C. Its fixed configuration is bit 6 set plus the RAM-size code in bits 1:0.
- R5: Variant B (VARIANT = VAR_B) has read-only mask 32'hF00FC04C. Its fixed configuration sets bits 31:28 to 4'h1, bits 3:2 to 2'b11 and bit 19, plus the RAM-size code in bits 1:0.
- R6: The RAM-size code on variant A is 0/1/2/3 for 64/128/256/512 MB. On variant B it is 0/1/2/3 for 128/256/512/1024 MB. Any other size gives code 2 on both variants, which means 256 MB on A and 512 MB on B.
- R7: On variant B, a write to offset 0x60 stores the data with bit 0 cleared. A write to offset 0x70 stores the data with bit 12 set and bit 13 cleared. On variant A, both offsets store the data unchanged.
- R8: After reset, every register reads 0 except offset 0x04, which holds the fixed configuration value. The bank is locked.
- R9: The register index is the byte address shifted right by 2. The two low address bits are ignored. Indices at or above NUM_WORDS (64) read as 0, and writes to them change no register.
- R10: err_o is high in the cycle after an accepted request that was either out of range or a write to a non-zero offset while locked. Otherwise err_o is low.
- R11: rsp_rdata_o shows the addressed register in the same cycle as a valid read request. It is 0 when no valid read is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ram_mb_i | input | 11 | RAM size strap in MB, sampled while reset is asserted |
| req_valid_i | input | 1 | Request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, combinational |
| err_o | output | 1 | One-cycle error pulse |

## Verification
A wrong lock bit shows up at the ports in two ways. Writes that should have been dropped become visible on the next read of the same word. The error pulse also appears or goes missing one cycle after the offending write. A corrupted filter or fixed value is visible on the very next read of offset 0x04, 0x60 or 0x70. An index aliasing fault can be seen by writing past the array and then reading the low words. The bench runs both variants side by side against a behavioural model across several strap values, including unsupported sizes. It compares read data and the error pulse on every cycle.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

  typedef enum logic {VAR_A = 1'b0, VAR_B = 1'b1} variant_e;

  localparam logic [31:0] UNLOCK_KEY = 32'hFC60_0309;

  localparam int unsigned IDX_LOCK = 0;
  localparam int unsigned IDX_CONF = 1;
  localparam int unsigned IDX_PHY  = 24;
  localparam int unsigned IDX_ECC  = 28;

  localparam int unsigned PHY_BUSY_BIT = 0;
  localparam int unsigned ECC_DONE_BIT = 12;
  localparam int unsigned ECC_FAIL_BIT = 13;

  localparam logic [31:0] RO_MASK_A = 32'hFFFF_F800 | 32'h0000_0040 | 32'h0000_000C;
  localparam logic [31:0] RO_MASK_B = 32'hF000_0000 | 32'h0008_0000 | 32'h0007_C000
                                    | 32'h0000_0040 | 32'h0000_000C;

  function automatic logic [31:0] ro_mask(variant_e v);
    return (v == VAR_A) ? RO_MASK_A : RO_MASK_B;
  endfunction

  function automatic logic [1:0] size_code(variant_e v, int unsigned mb);
    logic [1:0] c;
    c = 2'd2;
    if (v == VAR_A) begin
      case (mb)
        64:      c = 2'd0;
        128:     c = 2'd1;
        256:     c = 2'd2;
        512:     c = 2'd3;
        default: c = 2'd2;
      endcase
    end else begin
      case (mb)
        128:     c = 2'd0;
        256:     c = 2'd1;
        512:     c = 2'd2;
        1024:    c = 2'd3;
        default: c = 2'd2;
      endcase
    end
    return c;
  endfunction

  function automatic logic [31:0] fixed_conf(variant_e v, int unsigned mb);
    logic [31:0] f;
    if (v == VAR_A) f = 32'h0000_0040;
    else            f = 32'h1000_0000 | 32'h0008_0000 | 32'h0000_000C;
    f[1:0] = size_code(v, mb);
    return f;
  endfunction

endpackage

// File: rtl/mcb_decode.sv
module mcb_decode #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_WORDS = 64,
  localparam int unsigned IDX_W    = ADDR_W - 2,
  localparam int unsigned SEL_W    = $clog2(NUM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              in_range_o,
  output logic              hit_lock_o,
  output logic              hit_conf_o,
  output logic              hit_phy_o,
  output logic              hit_ecc_o
);
  import mcb_pkg::*;

  logic [IDX_W-1:0] word_idx;
  logic             unused_byte_lane;

  assign word_idx         = addr_i[ADDR_W-1:2];
  assign unused_byte_lane = ^addr_i[1:0];

  assign in_range_o = (word_idx < IDX_W'(NUM_WORDS));
  assign sel_o      = word_idx[SEL_W-1:0];
  assign hit_lock_o = (word_idx == IDX_W'(IDX_LOCK));
  assign hit_conf_o = (word_idx == IDX_W'(IDX_CONF));
  assign hit_phy_o  = (word_idx == IDX_W'(IDX_PHY));
  assign hit_ecc_o  = (word_idx == IDX_W'(IDX_ECC));

endmodule

// File: rtl/mcb_wfilter.sv
module mcb_wfilter #(
  parameter mcb_pkg::variant_e VARIANT = mcb_pkg::VAR_B
) (
  input  logic        hit_lock_i,
  input  logic        hit_conf_i,
  input  logic        hit_phy_i,
  input  logic        hit_ecc_i,
  input  logic [31:0] fixed_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] wdata_o
);
  import mcb_pkg::*;

  localparam logic [31:0] RO = ro_mask(VARIANT);

  logic [31:0] status_d;

  generate
    if (VARIANT == VAR_B) begin : g_status_filt
      always_comb begin
        status_d = wdata_i;
        if (hit_phy_i) status_d[PHY_BUSY_BIT] = 1'b0;
        if (hit_ecc_i) begin
          status_d[ECC_DONE_BIT] = 1'b1;
          status_d[ECC_FAIL_BIT] = 1'b0;
        end
      end
    end else begin : g_status_pass
      logic unused_hits;
      assign unused_hits = hit_phy_i ^ hit_ecc_i;
      assign status_d    = wdata_i;
    end
  endgenerate

  always_comb begin
    if (hit_lock_i)      wdata_o = {31'b0, wdata_i == UNLOCK_KEY};
    else if (hit_conf_i) wdata_o = (wdata_i & ~RO) | fixed_i;
    else                 wdata_o = status_d;
  end

endmodule

// File: rtl/mcb_regfile.sv
module mcb_regfile #(
  parameter int unsigned NUM_WORDS = 64,
  localparam int unsigned SEL_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       conf_rst_i,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  widx_i,
  input  logic [31:0]       wdata_i,
  input  logic [SEL_W-1:0]  ridx_i,
  output logic [31:0]       rdata_o,
  output logic [31:0]       conf_o,
  output logic              unlocked_o
);
  import mcb_pkg::*;

  logic [31:0] mem_q [NUM_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_WORDS); i++)
        mem_q[i] <= (i == int'(IDX_CONF)) ? conf_rst_i : 32'h0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  assign rdata_o    = mem_q[ridx_i];
  assign conf_o     = mem_q[IDX_CONF];
  assign unlocked_o = mem_q[IDX_LOCK][0];

  // R1: lock word never holds anything but 0 or 1
  a_r1_lock_binary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_q[IDX_LOCK][31:1] == 31'h0);

  // R2: write strobe to a non-lock word only arrives while unlocked
  a_r2_we_needs_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && widx_i != SEL_W'(IDX_LOCK)) |-> unlocked_o);

endmodule

// File: rtl/memctl_cfg_bank.sv
module memctl_cfg_bank #(
  parameter mcb_pkg::variant_e VARIANT = mcb_pkg::VAR_B,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_WORDS = 64,
  parameter int unsigned RAM_MB_W  = 11,
  localparam int unsigned SEL_W    = $clog2(NUM_WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [RAM_MB_W-1:0] ram_mb_i,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [31:0]         req_wdata_i,
  output logic [31:0]         rsp_rdata_o,
  output logic                err_o
);
  import mcb_pkg::*;

  localparam logic [31:0] RO = ro_mask(VARIANT);

  logic [SEL_W-1:0] sel;
  logic             in_range, hit_lock, hit_conf, hit_phy, hit_ecc;
  logic [31:0]      fixed, wdata_f, rd_word, conf_q;
  logic             unlocked, wr_en, bad_req, err_q;

  assign fixed = fixed_conf(VARIANT, int'(ram_mb_i));

  mcb_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_decode (
    .addr_i     (req_addr_i),
    .sel_o      (sel),
    .in_range_o (in_range),
    .hit_lock_o (hit_lock),
    .hit_conf_o (hit_conf),
    .hit_phy_o  (hit_phy),
    .hit_ecc_o  (hit_ecc)
  );

  mcb_wfilter #(.VARIANT(VARIANT)) u_wfilter (
    .hit_lock_i (hit_lock),
    .hit_conf_i (hit_conf),
    .hit_phy_i  (hit_phy),
    .hit_ecc_i  (hit_ecc),
    .fixed_i    (fixed),
    .wdata_i    (req_wdata_i),
    .wdata_o    (wdata_f)
  );

  assign wr_en   = req_valid_i && req_write_i && in_range && (hit_lock || unlocked);
  assign bad_req = req_valid_i && (!in_range || (req_write_i && !hit_lock && !unlocked));

  mcb_regfile #(.NUM_WORDS(NUM_WORDS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .conf_rst_i (fixed),
    .we_i       (wr_en),
    .widx_i     (sel),
    .wdata_i    (wdata_f),
    .ridx_i     (sel),
    .rdata_o    (rd_word),
    .conf_o     (conf_q),
    .unlocked_o (unlocked)
  );

  assign rsp_rdata_o = (req_valid_i && !req_write_i && in_range) ? rd_word : 32'h0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= bad_req;
  end
  assign err_o = err_q;

  // R3: read-only fields of the config word always track the fixed value
  a_r3_conf_ro_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conf_q & RO) == (fixed & RO));

  // R4 / R5: fixed bits are always present in the config word
  a_r5_conf_fixed_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conf_q & fixed) == fixed);

  // R10: an error pulse always traces back to a bad request one cycle earlier
  a_r10_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_valid_i));

  // R9: out-of-range reads return zero
  a_r9_oor_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && !in_range) |-> (rsp_rdata_o == 32'h0));

  generate
    if (VARIANT == VAR_B) begin : g_chk_status
      // R7: PHY never reads busy, ECC test never reads failed
      a_r7_phy_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !req_write_i && hit_phy) |-> !rsp_rdata_o[PHY_BUSY_BIT]);
      a_r7_ecc_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !req_write_i && hit_ecc) |-> !rsp_rdata_o[ECC_FAIL_BIT]);
    end
  endgenerate

endmodule

// File: tb/memctl_cfg_bank_tb_top.sv
`timescale 1ns/1ps
module memctl_cfg_bank_tb_top;

  localparam logic [31:0] KEY = 32'hFC600309;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] ram_mb = 11'd256;
  logic        valid = 1'b0, write = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd [2];
  logic        err [2];

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;
  logic [31:0] m [2][64];
  int cur_mb = 256;

  always #2.5 clk = ~clk;

  memctl_cfg_bank #(.VARIANT(mcb_pkg::VAR_A)) dut_a (
    .clk_i(clk), .rst_ni(rst_ni), .ram_mb_i(ram_mb), .req_valid_i(valid),
    .req_write_i(write), .req_addr_i(addr), .req_wdata_i(wdata),
    .rsp_rdata_o(rd[0]), .err_o(err[0]));

  memctl_cfg_bank #(.VARIANT(mcb_pkg::VAR_B)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ram_mb_i(ram_mb), .req_valid_i(valid),
    .req_write_i(write), .req_addr_i(addr), .req_wdata_i(wdata),
    .rsp_rdata_o(rd[1]), .err_o(err[1]));

  function automatic logic [31:0] mask_of(int v);
    return (v == 0) ? 32'hFFFFF84C : 32'hF00FC04C;
  endfunction

  function automatic logic [31:0] fix_of(int v, int mb);
    int code;
    if (v == 0) code = (mb == 64) ? 0 : (mb == 128) ? 1 : (mb == 512) ? 3 : 2;
    else        code = (mb == 128) ? 0 : (mb == 256) ? 1 : (mb == 1024) ? 3 : 2;
    if (v == 0) return 32'h40 | 32'(code);
    return 32'h1008000C | 32'(code);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, int v);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s variant %0d: actual %08h expected %08h", tag, v, act, exp);
    end
  endtask

  task automatic step(bit vl, bit wr, logic [11:0] a, logic [31:0] d, string tag);
    int idx;
    logic [31:0] exp_rd [2];
    bit exp_err [2];
    idx = int'(a >> 2);
    @(negedge clk);
    valid = vl; write = wr; addr = a; wdata = d;
    for (int v = 0; v < 2; v++) begin
      exp_rd[v]  = (vl && !wr && idx < 64) ? m[v][idx] : 32'h0;
      exp_err[v] = vl && (idx >= 64 || (wr && idx != 0 && m[v][0] == 0));
    end
    #1;
    for (int v = 0; v < 2; v++) chk(tag, rd[v], exp_rd[v], v); // R11 same-cycle data
    @(posedge clk);
    #1;
    for (int v = 0; v < 2; v++) chk("R10", {31'b0, err[v]}, {31'b0, exp_err[v]}, v);
    if (vl && wr && idx < 64) begin
      for (int v = 0; v < 2; v++) begin
        if (idx == 0) m[v][0] = (d == KEY) ? 32'd1 : 32'd0;
        else if (m[v][0] != 0) begin
          logic [31:0] f;
          f = d;
          if (idx == 1) f = (d & ~mask_of(v)) | fix_of(v, cur_mb);
          else if (v == 1 && idx == 24) f = d & ~32'h1;
          else if (v == 1 && idx == 28) f = (d | 32'h1000) & ~32'h2000;
          m[v][idx] = f;
        end
      end
    end
  endtask

  task automatic do_reset(int mb);
    @(negedge clk);
    rst_ni = 1'b0; valid = 1'b0;
    ram_mb = 11'(mb); cur_mb = mb;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    for (int v = 0; v < 2; v++) begin
      for (int i = 0; i < 64; i++) m[v][i] = 32'h0;
      m[v][1] = fix_of(v, mb);
    end
  endtask

  task automatic scenario(int mb);
    do_reset(mb);
    for (int i = 0; i < 64; i++) step(1, 0, 12'(i * 4), 0, (i == 1) ? "R6" : "R8");
    step(0, 0, 0, 0, "R10");
    // R2: locked writes dropped
    step(1, 1, 12'h014, 32'hDEADBEEF, "R2");
    step(1, 0, 12'h014, 0, "R2");
    step(1, 1, 12'h004, 32'h0, "R2");
    step(1, 0, 12'h004, 0, "R2");
    // R1: near-miss key keeps it locked
    step(1, 1, 12'h000, 32'hFC600308, "R1");
    step(1, 0, 12'h000, 0, "R1");
    // R9: low address bits ignored
    step(1, 1, 12'h003, KEY, "R9");
    step(1, 0, 12'h002, 0, "R9");
    // R3 R4 R5: config filter
    step(1, 1, 12'h004, 32'hFFFFFFFF, "R3");
    step(1, 0, 12'h004, 0, "R4");
    step(1, 1, 12'h004, 32'h0, "R3");
    step(1, 0, 12'h004, 0, "R5");
    // R7: status filters
    step(1, 1, 12'h060, 32'hFFFFFFFF, "R7");
    step(1, 0, 12'h060, 0, "R7");
    step(1, 1, 12'h070, 32'h0, "R7");
    step(1, 0, 12'h070, 0, "R7");
    step(1, 1, 12'h070, 32'hFFFFFFFF, "R7");
    step(1, 0, 12'h070, 0, "R7");
    // R11: general read-write
    for (int i = 2; i < 64; i++) step(1, 1, 12'(i * 4), 32'(i) * 32'h01010101 ^ 32'hA5A55A5A, "R11");
    for (int i = 2; i < 64; i++) step(1, 0, 12'(i * 4), 0, "R11");
    // R9: out of range
    step(1, 0, 12'h100, 0, "R9");
    step(1, 1, 12'h100, 32'h0, "R9");
    step(1, 0, 12'h000, 0, "R9");
    step(1, 1, 12'hFFC, 32'h12345678, "R9");
    step(1, 0, 12'h0FC, 0, "R9");
    // R1 relock, R2 lock word stays writable
    step(1, 1, 12'h000, 32'h1, "R1");
    step(1, 0, 12'h000, 0, "R1");
    step(1, 1, 12'h008, 32'h0, "R2");
    step(1, 0, 12'h008, 0, "R2");
    step(1, 1, 12'h000, KEY, "R2");
    step(1, 0, 12'h000, 0, "R2");
    step(0, 1, 12'h008, 32'h0, "R10");
    step(1, 0, 12'h008, 0, "R10");
  endtask

  initial begin
    int sizes [6] = '{64, 128, 256, 512, 1024, 100};
    do_reset(256);
    foreach (sizes[k]) scenario(sizes[k]);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule